// File: doc/BRIEF.md
# Parking Bus Arbiter with Repeat Allowance

This block decides which of several bus masters owns a shared address bus. Each master raises a request line and receives a registered, one-hot grant. Master 0 is the CPU. A grant to a requesting master is a tenure. The tenure ends when the transaction-done strobe pulses. At that moment the arbiter either lets the same master continue or passes the bus round-robin to the other requesters. A configurable repeat allowance lets one master run several transactions back to back.

When no master requests, the bus is parked. It can go to a fixed master, to the most recent owner, or to no master at all. An address-retry input ends any tenure at once. In the cycle that follows a retry, the bus is either parked on the CPU or left ungranted. The configuration inputs are plain levels that an outside register block drives.

Top module: `parb_top`

## Requirements
- R1: While reset is high, and in the first cycle after it, no grant is asserted unless parking calls for one. Reset also forgets the last owner, so last-owner parking then targets master 0.
- R2: At most one grant bit is high in any cycle.
- R3: A new tenure goes to the first requesting master in the order last owner + 1, last owner + 2, and so on, wrapping around. With no last owner, the search starts at master 0.
- R4: A repeat field value N (3 bits) allows N+1 consecutive transactions by the same requesting master. Value 0 gives one transaction and value 7 gives eight. When the allowance is used up, R3 applies.
- R5: If the owner has dropped its request when its transaction completes, the bus moves to another requester by R3.
- R6: Park mode 2'b00 grants the master whose index equals the 4-bit park-select field, when that field is 0, 1 or 2.
- R7: Park mode 2'b01 grants the last tenure owner, or master 0 if there has been none since reset.
- R8: Park mode 2'b10, park mode 2'b11, or mode 2'b00 with a park-select value of 3 or more leaves all grants low while no master requests.
- R9: A retry pulse ends any tenure. In the next cycle, master 0 alone is granted if the retry-park control is 0, and no master is granted if it is 1.
- R10: During a tenure, the grant holds steady until the done strobe or a retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_MASTERS | Request per master, bit i is master i |
| retry_i | input | 1 | Address retry pulse |
| xfer_done_i | input | 1 | Current transaction completes this cycle |
| cfg_repeat_i | input | RPT_W | Extra back-to-back transactions allowed |
| cfg_park_mode_i | input | 2 | 00 fixed, 01 last owner, 10/11 none |
| cfg_park_sel_i | input | SEL_W | Fixed park master index |
| cfg_retry_nopark_i | input | 1 | 1: no grant in the cycle after retry |
| gnt_o | output | N_MASTERS | Registered one-hot grant |

## Verification
The bench builds the block with its defaults: three masters, the CPU at index 0, a 3-bit repeat field and a 4-bit park select. With three masters, the rotation visibly skips a non-requesting master and wraps past the top index. The 3-bit field reaches the full eight-transaction run. The 4-bit select reaches the reserved codes above 2, which must leave the bus unparked.

// File: rtl/parb_pkg.sv
package parb_pkg;
  typedef enum logic [1:0] {
    PARK_FIXED = 2'b00,
    PARK_LAST  = 2'b01,
    PARK_OFF   = 2'b10,
    PARK_RSVD  = 2'b11
  } park_mode_e;
endpackage

// File: rtl/parb_rr_pick.sv
module parb_rr_pick #(
  parameter int N_MASTERS = 3,
  localparam int IW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic [N_MASTERS-1:0] req,
  input  logic [IW-1:0]        start,
  output logic [IW-1:0]        pick,
  output logic                 found
);
  localparam logic [IW:0] NW = N_MASTERS[IW:0];
  logic [IW:0] cand;

  // scan from start, wrapping, first requester wins
  always_comb begin
    found = 1'b0;
    pick  = '0;
    cand  = '0;
    for (int i = 0; i < N_MASTERS; i++) begin
      cand = {1'b0, start} + i[IW:0];
      if (cand >= NW) cand = cand - NW;
      if (!found && req[cand[IW-1:0]]) begin
        found = 1'b1;
        pick  = cand[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/parb_park_sel.sv
module parb_park_sel
  import parb_pkg::*;
#(
  parameter int N_MASTERS = 3,
  parameter int CPU_IDX   = 0,
  parameter int SEL_W     = 4,
  localparam int IW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic [1:0]           mode,
  input  logic [SEL_W-1:0]     sel,
  input  logic [IW-1:0]        last,
  input  logic                 last_vld,
  output logic [N_MASTERS-1:0] park
);
  park_mode_e m;
  assign m = park_mode_e'(mode);

  always_comb begin
    park = '0;
    for (int i = 0; i < N_MASTERS; i++) begin
      unique case (m)
        PARK_FIXED: park[i] = (sel == SEL_W'(i));
        PARK_LAST:  park[i] = last_vld ? (last == IW'(i)) : (i == CPU_IDX);
        default:    park[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/parb_rpt_ctr.sv
module parb_rpt_ctr #(
  parameter int RPT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             bump,
  input  logic [RPT_W-1:0] limit,
  output logic             allow
);
  logic [RPT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (bump)    cnt_q <= cnt_q + 1'b1;
  end

  assign allow = cnt_q < limit;
endmodule

// File: rtl/parb_top.sv
module parb_top #(
  parameter int N_MASTERS = 3,
  parameter int CPU_IDX   = 0,
  parameter int RPT_W     = 3,
  parameter int SEL_W     = 4,
  localparam int IW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_MASTERS-1:0] req_i,
  input  logic                 retry_i,
  input  logic                 xfer_done_i,
  input  logic [RPT_W-1:0]     cfg_repeat_i,
  input  logic [1:0]           cfg_park_mode_i,
  input  logic [SEL_W-1:0]     cfg_park_sel_i,
  input  logic                 cfg_retry_nopark_i,
  output logic [N_MASTERS-1:0] gnt_o
);
  localparam logic [N_MASTERS-1:0] CPU_OH = N_MASTERS'(1) << CPU_IDX;

  logic [N_MASTERS-1:0] gnt_q, gnt_d, park;
  logic                 busy_q, busy_d;
  logic [IW-1:0]        last_q, last_d, rr_start, pick;
  logic                 last_vld_q, last_vld_d, found;
  logic                 cnt_clr, cnt_bump, rpt_allow, boundary;

  assign rr_start = !last_vld_q ? '0 :
                    (last_q == IW'(N_MASTERS - 1)) ? '0 : last_q + 1'b1;

  parb_rr_pick #(.N_MASTERS(N_MASTERS)) u_pick (
    .req(req_i), .start(rr_start), .pick(pick), .found(found)
  );

  parb_park_sel #(.N_MASTERS(N_MASTERS), .CPU_IDX(CPU_IDX), .SEL_W(SEL_W)) u_park (
    .mode(cfg_park_mode_i), .sel(cfg_park_sel_i), .last(last_q),
    .last_vld(last_vld_q), .park(park)
  );

  parb_rpt_ctr #(.RPT_W(RPT_W)) u_rpt (
    .clk(clk), .rst(rst), .clear(cnt_clr), .bump(cnt_bump),
    .limit(cfg_repeat_i), .allow(rpt_allow)
  );

  assign boundary = !busy_q || xfer_done_i;

  always_comb begin
    gnt_d      = gnt_q;
    busy_d     = busy_q;
    last_d     = last_q;
    last_vld_d = last_vld_q;
    cnt_clr    = 1'b0;
    cnt_bump   = 1'b0;
    if (retry_i) begin
      gnt_d   = cfg_retry_nopark_i ? '0 : CPU_OH;
      busy_d  = 1'b0;
      cnt_clr = 1'b1;
    end else if (boundary) begin
      if (found) begin
        if (busy_q && req_i[last_q] && rpt_allow) begin
          cnt_bump = 1'b1;
        end else begin
          gnt_d       = '0;
          gnt_d[pick] = 1'b1;
          busy_d      = 1'b1;
          last_d      = pick;
          last_vld_d  = 1'b1;
          cnt_clr     = 1'b1;
        end
      end else begin
        gnt_d   = park;
        busy_d  = 1'b0;
        cnt_clr = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q      <= '0;
      busy_q     <= 1'b0;
      last_q     <= '0;
      last_vld_q <= 1'b0;
    end else begin
      gnt_q      <= gnt_d;
      busy_q     <= busy_d;
      last_q     <= last_d;
      last_vld_q <= last_vld_d;
    end
  end

  assign gnt_o = gnt_q;

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_o)); // R2
  AST_TENURE_HOLD: assert property (@(posedge clk) disable iff (rst)
    busy_q && !xfer_done_i && !retry_i |=> $stable(gnt_o)); // R10
  AST_RETRY_CPU: assert property (@(posedge clk) disable iff (rst)
    retry_i && !cfg_retry_nopark_i |=> gnt_o == CPU_OH); // R9
  AST_RETRY_NONE: assert property (@(posedge clk) disable iff (rst)
    retry_i && cfg_retry_nopark_i |=> gnt_o == '0); // R9
  AST_IDLE_OFF: assert property (@(posedge clk) disable iff (rst)
    !busy_q && !retry_i && req_i == '0 && cfg_park_mode_i[1] |=> gnt_o == '0); // R8
endmodule

// File: tb/parb_top_tb.sv
module parb_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] req = '0;
  logic       retry = 1'b0, done = 1'b0, wop = 1'b0;
  logic [2:0] rpt = '0;
  logic [1:0] pm = '0;
  logic [3:0] ps = '0;
  logic [2:0] gnt;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  parb_top u_dut (
    .clk(clk), .rst(rst), .req_i(req), .retry_i(retry), .xfer_done_i(done),
    .cfg_repeat_i(rpt), .cfg_park_mode_i(pm), .cfg_park_sel_i(ps),
    .cfg_retry_nopark_i(wop), .gnt_o(gnt)
  );

  // {req, retry, done, rpt, park mode, park sel, retry-nopark, expected grant}
  localparam int NV = 34;
  localparam logic [17:0] VEC [NV] = '{
    {3'b000,1'b0,1'b0,3'd0,2'b00,4'd2,1'b0,3'b100},
    {3'b000,1'b0,1'b0,3'd0,2'b01,4'd0,1'b0,3'b001},
    {3'b000,1'b0,1'b0,3'd0,2'b10,4'd0,1'b0,3'b000},
    {3'b000,1'b0,1'b0,3'd0,2'b11,4'd0,1'b0,3'b000},
    {3'b000,1'b0,1'b0,3'd0,2'b00,4'd3,1'b0,3'b000},
    {3'b010,1'b0,1'b0,3'd0,2'b00,4'd0,1'b0,3'b010},
    {3'b010,1'b0,1'b0,3'd0,2'b00,4'd0,1'b0,3'b010},
    {3'b110,1'b0,1'b1,3'd0,2'b00,4'd0,1'b0,3'b100},
    {3'b110,1'b0,1'b1,3'd0,2'b00,4'd0,1'b0,3'b010},
    {3'b111,1'b0,1'b1,3'd0,2'b00,4'd0,1'b0,3'b100},
    {3'b111,1'b0,1'b1,3'd0,2'b00,4'd0,1'b0,3'b001},
    {3'b001,1'b0,1'b1,3'd2,2'b00,4'd0,1'b0,3'b001},
    {3'b011,1'b0,1'b1,3'd2,2'b00,4'd0,1'b0,3'b001},
    {3'b011,1'b0,1'b1,3'd2,2'b00,4'd0,1'b0,3'b010},
    {3'b011,1'b0,1'b1,3'd2,2'b00,4'd0,1'b0,3'b010},
    {3'b001,1'b0,1'b1,3'd2,2'b00,4'd0,1'b0,3'b001},
    {3'b000,1'b0,1'b1,3'd2,2'b01,4'd0,1'b0,3'b001},
    {3'b100,1'b0,1'b0,3'd2,2'b01,4'd0,1'b0,3'b100},
    {3'b000,1'b0,1'b1,3'd2,2'b01,4'd0,1'b0,3'b100},
    {3'b000,1'b1,1'b0,3'd0,2'b10,4'd0,1'b0,3'b001},
    {3'b000,1'b0,1'b0,3'd0,2'b10,4'd0,1'b0,3'b000},
    {3'b010,1'b0,1'b0,3'd0,2'b10,4'd0,1'b0,3'b010},
    {3'b010,1'b1,1'b0,3'd0,2'b10,4'd0,1'b1,3'b000},
    {3'b010,1'b0,1'b0,3'd0,2'b10,4'd0,1'b1,3'b010},
    {3'b011,1'b1,1'b0,3'd0,2'b10,4'd0,1'b0,3'b001},
    {3'b011,1'b0,1'b0,3'd0,2'b10,4'd0,1'b0,3'b001},
    {3'b101,1'b0,1'b1,3'd7,2'b10,4'd0,1'b0,3'b001},
    {3'b101,1'b0,1'b1,3'd7,2'b10,4'd0,1'b0,3'b001},
    {3'b101,1'b0,1'b1,3'd7,2'b10,4'd0,1'b0,3'b001},
    {3'b101,1'b0,1'b1,3'd7,2'b10,4'd0,1'b0,3'b001},
    {3'b101,1'b0,1'b1,3'd7,2'b10,4'd0,1'b0,3'b001},
    {3'b101,1'b0,1'b1,3'd7,2'b10,4'd0,1'b0,3'b001},
    {3'b101,1'b0,1'b1,3'd7,2'b10,4'd0,1'b0,3'b001},
    {3'b101,1'b0,1'b1,3'd7,2'b10,4'd0,1'b0,3'b100}
  };

  function automatic string tag_of(int i);
    if (i == 0) return "R6";
    if (i == 1 || i == 16 || i == 18) return "R7";
    if (i >= 2 && i <= 4) return "R8";
    if (i == 20) return "R8";
    if (i == 6) return "R10";
    if (i >= 11 && i <= 14) return "R4";
    if (i >= 26) return "R4";
    if (i == 15) return "R5";
    if (i == 19 || i == 22 || i == 24) return "R9";
    return "R3";
  endfunction

  task automatic check(input logic [2:0] exp, input string tag);
    checks++;
    if (gnt !== exp) begin
      fails++;
      $display("FAIL %s: grant actual %b expected %b at %0t", tag, gnt, exp, $time);
    end
  endtask

  task automatic check_r2();
    checks++;
    if ($countones(gnt) > 1) begin
      fails++;
      $display("FAIL R2: grant actual %b expected at most one bit", gnt);
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(3'b000, "R1");
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      {req, retry, done, rpt, pm, ps, wop} = VEC[i][17:3];
      @(negedge clk);
      check(VEC[i][2:0], tag_of(i));
      check_r2();
    end
    // reset during a tenure clears the grant and the last owner
    rst = 1'b1; req = 3'b101; retry = 1'b0; done = 1'b0;
    @(negedge clk);
    check(3'b000, "R1");
    rst = 1'b0; req = 3'b000; pm = 2'b01;
    @(negedge clk);
    check(3'b001, "R1");
    // with no last owner the search starts at master 0
    req = 3'b110;
    @(negedge clk);
    check(3'b010, "R3");
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule